// File: doc/BRIEF.md
# Line-sync and NMI pulse generator

This block produces the horizontal line-sync pulse, a software-gated stream of non-maskable interrupt pulses, and a software-driven vertical-sync level for a video scheme in which the processor builds each frame itself. A free-running line counter sets the line period. The processor resynchronises that counter during every interrupt-acknowledge cycle. An acknowledge cycle is any cycle in which the opcode-fetch strobe and the I/O request strobe are both low. While the acknowledge lasts, the counter is loaded with a fixed value and held there. The sync pulse therefore starts a fixed number of clocks after the acknowledge ends.

Two flags are controlled by I/O cycles. The first is an interrupt-enable flag: I/O writes set it and clear it, and the data value plays no part. The second is a vertical-sync flag: I/O reads set it and any I/O write clears it. A mode pin selects the machine behaviour. When the pin is high, interrupt pulses follow the line sync while the enable flag is set. When the pin is low, interrupts are never produced. All bus strobes are sampled on the rising clock edge, and all state is held in flip-flops.

Top module: `lsync_nmi_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the counter returns to 0 and both flags clear. During and just after reset, `hsync_n`, `nmi_n` and `vsync_n` are all high.
- R2: With no acknowledge, the counter advances by one each clock and wraps from 206 to 0. `hsync_n` is low exactly while the count is in 16..31, which gives one 16-clock pulse every 207 clocks.
- R3: At each edge where `m1_n` and `iorq_n` are both low, the counter is loaded with 0. It stays at 0 while that condition lasts, so `hsync_n` stays high for the whole hold.
- R4: After the last held edge, `hsync_n` falls on the 16th rising edge and not before.
- R5: An edge with `iorq_n`, `wr_n` and `a0` all low sets the interrupt-enable flag.
- R6: An edge with `iorq_n`, `wr_n` and `a1` all low clears the interrupt-enable flag. If `a0` and `a1` are both low in that write, the clear wins.
- R7: `nmi_n` is low exactly when `hsync_n` is low, the enable flag is set and `mode_nmi` is high. While `mode_nmi` is low, `nmi_n` stays high.
- R8: An edge with `iorq_n`, `rd_n` and `a0` all low sets the vertical-sync flag (`vsync_n` low) only if the enable flag is clear. While the flag is set, such a read has no effect.
- R9: Any edge with `iorq_n` and `wr_n` both low clears the vertical-sync flag, whatever the address. A write takes priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| m1_n | input | 1 | Opcode-fetch / acknowledge strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Address bit 0 |
| a1 | input | 1 | Address bit 1 |
| mode_nmi | input | 1 | High: interrupt pulses allowed; low: always blocked |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The embedded properties assume that every bus strobe is already synchronous to `clk` and is stable around each rising edge. They also assume that an acknowledge cycle is identified only by `m1_n` and `iorq_n` being low together. The stimulus changes inputs only on falling edges. Directed phases cover long acknowledge holds, set, clear and both-low writes, and reads with the enable flag in each state. A final mixed phase draws strobes at random. In that phase acknowledges are kept rare, so that full sync pulses still occur between reloads.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

    // Bus events decoded from one sampled clock cycle
    typedef struct packed {
        logic ack;      // interrupt-acknowledge: counter reload
        logic nmi_set;  // write, a0 low
        logic nmi_clr;  // write, a1 low
        logic vs_set;   // read, a0 low (before enable gating)
        logic vs_clr;   // any write
    } bus_evt_t;

    function automatic logic in_window(int unsigned v, int unsigned first, int unsigned width);
        return (v >= first) && (v < first + width);
    endfunction

endpackage

// File: rtl/lsync_bus_dec.sv
module lsync_bus_dec (
    input  logic              m1_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic              a1,
    output lsync_pkg::bus_evt_t evt
);
    logic io_wr;
    logic io_rd;

    always_comb begin
        io_wr       = !iorq_n && !wr_n;
        io_rd       = !iorq_n && !rd_n;
        evt.ack     = !m1_n && !iorq_n;
        evt.nmi_set = io_wr && !a0;
        evt.nmi_clr = io_wr && !a1;
        evt.vs_set  = io_rd && !a0;
        evt.vs_clr  = io_wr;
    end
endmodule

// File: rtl/lsync_line_ctr.sv
module lsync_line_ctr #(
    parameter int unsigned LINE_LEN   = 207,
    parameter int unsigned RELOAD_VAL = 0,
    parameter int unsigned SYNC_DELAY = 16,
    parameter int unsigned PULSE_W    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic hs_act
);
    localparam int unsigned CW       = $clog2(LINE_LEN);
    localparam int unsigned HS_FIRST = RELOAD_VAL + SYNC_DELAY;
    localparam logic [CW-1:0] LAST   = CW'(LINE_LEN - 1);
    localparam logic [CW-1:0] RELOAD = CW'(RELOAD_VAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (hold)        cnt <= RELOAD;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign hs_act = lsync_pkg::in_window(32'(cnt), HS_FIRST, PULSE_W);

    // R3: the acknowledge forces the reload value
    a_r3_reload_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == RELOAD));

    // R3: no sync pulse while held
    a_r3_no_sync_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> !hs_act);

    // R2: the counter never stalls when free
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (!hold && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));

    // R2: wrap at the end of the line
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (!hold && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/lsync_flag_regs.sv
module lsync_flag_regs (
    input  logic                clk,
    input  logic                rst,
    input  lsync_pkg::bus_evt_t evt,
    output logic                nmi_en,
    output logic                vs_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_en <= 1'b0;
            vs_on  <= 1'b0;
        end else begin
            if (evt.nmi_clr)      nmi_en <= 1'b0;
            else if (evt.nmi_set) nmi_en <= 1'b1;

            if (evt.vs_clr)                  vs_on <= 1'b0;
            else if (evt.vs_set && !nmi_en)  vs_on <= 1'b1;
        end
    end

    a_r5_enable_set: assert property (@(posedge clk) disable iff (rst)
        (evt.nmi_set && !evt.nmi_clr) |=> nmi_en);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        evt.nmi_clr |=> !nmi_en);

    // R8: with the enable flag set, vertical sync cannot start
    a_r8_locked_out: assert property (@(posedge clk) disable iff (rst)
        (nmi_en && !vs_on) |=> !vs_on);

    a_r9_write_clears_vs: assert property (@(posedge clk) disable iff (rst)
        evt.vs_clr |=> !vs_on);
endmodule

// File: rtl/lsync_nmi_gen.sv
module lsync_nmi_gen #(
    parameter int unsigned LINE_LEN   = 207,
    parameter int unsigned RELOAD_VAL = 0,
    parameter int unsigned SYNC_DELAY = 16,
    parameter int unsigned PULSE_W    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic m1_n,
    input  logic iorq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic a0,
    input  logic a1,
    input  logic mode_nmi,
    output logic nmi_n,
    output logic hsync_n,
    output logic vsync_n
);
    lsync_pkg::bus_evt_t evt;
    logic hs_act;
    logic nmi_en;
    logic vs_on;

    lsync_bus_dec dec_i (
        .m1_n   (m1_n),
        .iorq_n (iorq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .a0     (a0),
        .a1     (a1),
        .evt    (evt)
    );

    lsync_line_ctr #(
        .LINE_LEN   (LINE_LEN),
        .RELOAD_VAL (RELOAD_VAL),
        .SYNC_DELAY (SYNC_DELAY),
        .PULSE_W    (PULSE_W)
    ) ctr_i (
        .clk    (clk),
        .rst    (rst),
        .hold   (evt.ack),
        .hs_act (hs_act)
    );

    lsync_flag_regs flags_i (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .nmi_en (nmi_en),
        .vs_on  (vs_on)
    );

    assign hsync_n = !hs_act;
    assign nmi_n   = !(hs_act && nmi_en && mode_nmi);
    assign vsync_n = !vs_on;

    a_r7_mode_blocks: assert property (@(posedge clk) disable iff (rst)
        !mode_nmi |-> nmi_n);

    // R7: an interrupt pulse only ever appears inside a sync pulse
    a_r7_inside_sync: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |-> !hsync_n);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (nmi_n && vsync_n && hsync_n));
endmodule

// File: tb/lsync_nmi_gen_tb_top.sv
`timescale 1ns/1ps
module lsync_nmi_gen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic a0 = 1'b1, a1 = 1'b1, mode_nmi = 1'b1;
    logic nmi_n, hsync_n, vsync_n;

    int vectors = 0;
    int misses  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    int  m_cnt = 0;
    bit  m_en  = 0;
    bit  m_vs  = 0;

    always #2.5 clk = ~clk;

    lsync_nmi_gen dut_i (
        .clk(clk), .rst(rst), .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .a0(a0), .a1(a1), .mode_nmi(mode_nmi),
        .nmi_n(nmi_n), .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    always @(posedge clk) begin
        bit ack, wr, rd, en_old;
        if (rst) begin
            m_cnt = 0; m_en = 0; m_vs = 0;
        end else begin
            ack = !m1_n && !iorq_n;
            wr  = !iorq_n && !wr_n;
            rd  = !iorq_n && !rd_n;
            en_old = m_en;
            if (wr && !a1)      m_en = 0;
            else if (wr && !a0) m_en = 1;
            if (wr)                         m_vs = 0;
            else if (rd && !a0 && !en_old)  m_vs = 1;
            if (ack)               m_cnt = 0;
            else if (m_cnt == 206) m_cnt = 0;
            else                   m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(string req, string what, logic got, logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s got %b expected %b", req, what, got, exp);
        end
    endtask

    // wait to the falling edge and compare every output against the model
    task automatic tick();
        bit hs;
        @(negedge clk);
        hs = (m_cnt >= 16) && (m_cnt < 32);
        chk(cur_req, "hsync_n", hsync_n, !hs);
        chk(cur_req, "nmi_n",   nmi_n,   !(hs && m_en && mode_nmi));
        chk(cur_req, "vsync_n", vsync_n, !m_vs);
    endtask

    task automatic idle();
        m1_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; a0 = 1; a1 = 1;
    endtask

    task automatic io_write(bit b0, bit b1);
        iorq_n = 0; wr_n = 0; a0 = b0; a1 = b1;
        tick();
        idle();
    endtask

    task automatic io_read(bit b0);
        iorq_n = 0; rd_n = 0; a0 = b0;
        tick();
        idle();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL %s watchdog expired got running expected finished", cur_req);
        report();
    end

    initial begin
        int gap;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "hsync_n in reset", hsync_n, 1'b1);
        chk("R1", "nmi_n in reset", nmi_n, 1'b1);
        chk("R1", "vsync_n in reset", vsync_n, 1'b1);
        rst = 0;
        tick();

        // R2: free-running period and pulse width
        cur_req = "R2";
        gap = 0;
        while (hsync_n !== 1'b0 && gap < 400) begin tick(); gap++; end
        gap = 0;
        while (hsync_n === 1'b0 && gap < 400) begin tick(); gap++; end
        chk("R2", "pulse width is 16", 1'(gap == 16), 1'b1);
        while (hsync_n !== 1'b0 && gap < 800) begin tick(); gap++; end
        chk("R2", "line period is 207", 1'(gap == 207), 1'b1);
        run(250);

        // R3 and R4: acknowledge hold then release
        cur_req = "R3";
        m1_n = 0; iorq_n = 0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (i > 0) chk("R3", "hsync_n held high", hsync_n, 1'b1);
        end
        idle();
        cur_req = "R4";
        for (int i = 1; i <= 16; i++) begin
            tick();
            if (i == 15) chk("R4", "hsync_n before 16th edge", hsync_n, 1'b1);
            if (i == 16) chk("R4", "hsync_n at 16th edge", hsync_n, 1'b0);
        end
        run(220);

        // R5: enable via write with a0 low, pulses follow sync
        cur_req = "R5";
        io_write(1'b0, 1'b1);
        run(240);

        // R6: clear via a1 low, and clear-wins with both low
        cur_req = "R6";
        io_write(1'b1, 1'b0);
        run(230);
        io_write(1'b0, 1'b1);
        io_write(1'b0, 1'b0);
        run(230);

        // R7: mode pin blocks interrupts while enabled
        cur_req = "R7";
        io_write(1'b0, 1'b1);
        mode_nmi = 0;
        run(230);
        mode_nmi = 1;
        run(230);

        // R8: read with enable set is ignored; with enable clear it sets vsync
        cur_req = "R8";
        io_read(1'b0);
        tick();
        chk("R8", "vsync_n ignored while enabled", vsync_n, 1'b1);
        io_write(1'b1, 1'b0);
        io_read(1'b1);
        tick();
        chk("R8", "vsync_n with a0 high", vsync_n, 1'b1);
        io_read(1'b0);
        tick();
        chk("R8", "vsync_n set by read", vsync_n, 1'b0);

        // R9: any write clears vsync
        cur_req = "R9";
        io_write(1'b1, 1'b1);
        chk("R9", "vsync_n after write", vsync_n, 1'b1);
        io_read(1'b0);
        iorq_n = 0; rd_n = 0; wr_n = 0; a0 = 0; a1 = 0;
        tick();
        idle();
        tick();
        chk("R9", "write beats read", vsync_n, 1'b1);

        // mixed random phase
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            idle();
            if (r < 2)       begin m1_n = 0; iorq_n = 0; end
            else if (r < 6)  begin iorq_n = 0; wr_n = 0; a0 = 1'($urandom); a1 = 1'($urandom); end
            else if (r < 10) begin iorq_n = 0; rd_n = 0; a0 = 1'($urandom); end
            else if (r < 11) mode_nmi = ~mode_nmi;
            tick();
        end
        idle();
        mode_nmi = 1;
        run(5);
        report();
    end
endmodule